// File: doc/BRIEF.md
# Two-Wire Register Slave with Word Auto-Increment

This block is a slave on a two-wire serial bus that gives a bus master access to a bank of 16-bit control registers. It samples the clock and data lines through a synchronizer on a fast system clock. It finds start and stop conditions, matches a fixed 7-bit device address and acknowledges every byte it accepts. On a write it builds each register word from two bytes, high byte first, and issues a one-cycle write strobe to the register file once the word is complete. On a read it fetches the word at the current register pointer and shifts it out high byte first.

The register pointer is loaded from the byte that follows a write-mode device address. It advances by one after every complete 16-bit word, in both directions, and wraps from the top of the address space to zero. A read is a write-mode address plus a register address, then a repeated start with the read-mode address. The register file itself sits outside the block. It is reached through a write strobe with address and data, and a read address with a data return. The data line is driven only as an open-drain pull-down enable.

Top module: `twi_reg_slave`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, the pull-down enable `sda_oe` and the write strobe `rf_we` are both low.
- R2: A start (SDA falling while SCL is high) begins a transaction from any state. A stop (SDA rising while SCL is high) ends it, and the pull-down enable is low in the cycle after a stop is detected.
- R3: The first byte after a start is the device address, sent MSB first. Its upper seven bits must equal 1011100 and its LSB selects the direction (0 = write, 0xB8; 1 = read, 0xB9). A matching byte is acknowledged by holding SDA low during the ninth clock. For any other value the slave leaves SDA released for the whole rest of the transaction, including every acknowledge slot, until the next start.
- R4: After a write-mode device address, the next byte is taken as the 8-bit register address, loaded into the register pointer and acknowledged.
- R5: Data bytes that follow the register address are acknowledged and paired into 16-bit words, first byte as bits 15:8 and second byte as bits 7:0. Each complete word produces exactly one `rf_we` pulse, one system clock wide, carrying the pointer value and the word.
- R6: After every complete 16-bit word, and not after single bytes, the register pointer advances by one. It wraps from 0xFF to 0x00.
- R7: If a stop or a repeated start arrives when only the first byte of a word has been received, that byte is discarded and no write strobe is issued for it.
- R8: After a repeated start with the read-mode address, the slave returns the word at the register pointer, high byte first and MSB first within each byte. When the master acknowledges the low byte, the slave continues with the word at the next pointer value.
- R9: When the master does not acknowledge a read byte, the slave releases SDA and drives nothing more until the next start.
- R10: The slave changes its SDA drive only while SCL is low, so SDA never changes by the slave's action while SCL is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8 times the bus clock rate |
| rst | input | 1 | Synchronous reset, active high |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | Pull-down enable for the open-drain data pad; 1 pulls SDA low |
| rf_we | output | 1 | One-cycle write strobe to the register file |
| rf_waddr | output | 8 | Register address that goes with `rf_we` |
| rf_wdata | output | 16 | Register word that goes with `rf_we` |
| rf_raddr | output | 8 | Current register pointer, used as the read address |
| rf_rdata | input | 16 | Register word at `rf_raddr`, returned by the register file |

## Verification
The bench builds the block with its default parameters: the device address 1011100, 16-bit registers behind an 8-bit pointer, and a two-stage synchronizer. It runs the bus at a quarter period of eight system clocks, which gives 32 samples per bit. At these sizes the pointer wrap from 0xFF to 0x00 is reached with one two-word burst. The two-byte word assembly brings the partial-word cases within reach: a stop after one odd byte, and a repeated start after one byte. Multi-word bursts in both directions exercise the per-word increment, and the cycle-level margin between the synchronized SCL edges and the SDA drive changes is small enough to expose timing mistakes.

// File: rtl/twi_pkg.sv
package twi_pkg;

  // Protocol phase of the slave controller
  typedef enum logic [2:0] {
    ST_IDLE,   // not addressed, waits for a start
    ST_DEV,    // receiving the device address byte
    ST_REG,    // receiving the register address byte
    ST_WDATA,  // receiving data bytes of a write
    ST_ACK,    // driving the acknowledge for a received byte
    ST_RDATA,  // shifting a read byte out
    ST_MACK    // sampling the master's acknowledge after a read byte
  } twi_state_t;

  localparam int BYTE_W = 8;

endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RESET_VAL}};
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/twi_bus_events.sv
module twi_bus_events #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  localparam int NLINES = 2;

  logic [NLINES-1:0] raw;
  logic [NLINES-1:0] synced;
  logic              scl_q, sda_q;

  assign raw = {sda_i, scl_i};

  for (genvar gi = 0; gi < NLINES; gi++) begin : g_sync
    twi_line_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
      .clk (clk),
      .rst (rst),
      .d   (raw[gi]),
      .q   (synced[gi])
    );
  end

  assign scl_s = synced[0];
  assign sda_s = synced[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  =  scl_s & ~scl_q;
  assign scl_fall  = ~scl_s &  scl_q;
  assign start_det =  scl_s &  scl_q &  sda_q & ~sda_s;
  assign stop_det  =  scl_s &  scl_q & ~sda_q &  sda_s;

endmodule

// File: rtl/twi_ctrl.sv
module twi_ctrl
  import twi_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'b1011100,
  parameter int         AW       = 8,
  parameter int         DW       = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          sda_s,
  input  logic          start_det,
  input  logic          stop_det,
  output logic          sda_oe,
  output logic          rf_we,
  output logic [AW-1:0] rf_waddr,
  output logic [DW-1:0] rf_wdata,
  output logic [AW-1:0] rf_raddr,
  input  logic [DW-1:0] rf_rdata
);

  localparam int BYTES = DW / BYTE_W;
  localparam int BIW   = (BYTES > 1) ? $clog2(BYTES) : 1;
  localparam logic [BIW-1:0] LAST_IDX = BIW'(BYTES - 1);
  localparam logic [AW-1:0]  PTR_STEP = AW'(1);
  localparam logic [3:0]     BITS_DONE = 4'd8;

  twi_state_t        state, nxt_state;
  logic [3:0]        bitcnt;
  logic [7:0]        rx_byte;
  logic [AW-1:0]     ptr;
  logic [DW-1:0]     wacc;
  logic [BIW-1:0]    widx;
  logic [DW-1:0]     rword;
  logic [BIW-1:0]    ridx;
  logic [7:0]        txb;
  logic              nack;

  // Word that takes the newly received byte at its low end
  logic [DW-1:0]     wacc_next;
  // Word and byte that the next read byte is taken from
  logic [DW-1:0]     ld_word;
  logic [7:0]        ld_byte;

  always_comb begin
    wacc_next = (wacc << BYTE_W) | DW'(rx_byte);
    ld_word   = (ridx == '0) ? rf_rdata : rword;
    ld_byte   = ld_word[DW-1 -: BYTE_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      nxt_state <= ST_IDLE;
      bitcnt    <= '0;
      rx_byte   <= '0;
      ptr       <= '0;
      wacc      <= '0;
      widx      <= '0;
      rword     <= '0;
      ridx      <= '0;
      txb       <= '0;
      nack      <= 1'b0;
      sda_oe    <= 1'b0;
      rf_we     <= 1'b0;
      rf_waddr  <= '0;
      rf_wdata  <= '0;
    end else begin
      rf_we <= 1'b0;
      if (start_det) begin
        state  <= ST_DEV;
        bitcnt <= '0;
        widx   <= '0;
        ridx   <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        state  <= ST_IDLE;
        widx   <= '0;
        sda_oe <= 1'b0;
      end else begin
        unique case (state)
          ST_DEV, ST_REG, ST_WDATA: begin
            if (scl_rise) begin
              rx_byte <= {rx_byte[6:0], sda_s};
              bitcnt  <= bitcnt + 4'd1;
            end
            if (scl_fall && bitcnt == BITS_DONE) begin
              bitcnt <= '0;
              if (state == ST_DEV) begin
                if (rx_byte[7:1] == DEV_ADDR) begin
                  sda_oe    <= 1'b1;
                  state     <= ST_ACK;
                  nxt_state <= rx_byte[0] ? ST_RDATA : ST_REG;
                  ridx      <= '0;
                end else begin
                  state <= ST_IDLE;
                end
              end else if (state == ST_REG) begin
                ptr       <= AW'(rx_byte);
                widx      <= '0;
                sda_oe    <= 1'b1;
                state     <= ST_ACK;
                nxt_state <= ST_WDATA;
              end else begin
                wacc <= wacc_next;
                if (widx == LAST_IDX) begin
                  rf_we    <= 1'b1;
                  rf_waddr <= ptr;
                  rf_wdata <= wacc_next;
                  ptr      <= ptr + PTR_STEP;
                  widx     <= '0;
                end else begin
                  widx <= widx + BIW'(1);
                end
                sda_oe    <= 1'b1;
                state     <= ST_ACK;
                nxt_state <= ST_WDATA;
              end
            end
          end

          ST_ACK: begin
            if (scl_fall) begin
              state  <= nxt_state;
              bitcnt <= '0;
              if (nxt_state == ST_RDATA) begin
                txb    <= ld_byte;
                rword  <= ld_word << BYTE_W;
                sda_oe <= ~ld_byte[7];
              end else begin
                sda_oe <= 1'b0;
              end
            end
          end

          ST_RDATA: begin
            if (scl_rise) bitcnt <= bitcnt + 4'd1;
            if (scl_fall) begin
              if (bitcnt == BITS_DONE) begin
                sda_oe <= 1'b0;
                state  <= ST_MACK;
                bitcnt <= '0;
                if (ridx == LAST_IDX) begin
                  ridx <= '0;
                  ptr  <= ptr + PTR_STEP;
                end else begin
                  ridx <= ridx + BIW'(1);
                end
              end else if (bitcnt != '0) begin
                txb    <= txb << 1;
                sda_oe <= ~txb[6];
              end
            end
          end

          ST_MACK: begin
            if (scl_rise) begin
              nack   <= sda_s;
              bitcnt <= 4'd1;
            end
            if (scl_fall && bitcnt == 4'd1) begin
              bitcnt <= '0;
              if (nack) begin
                state <= ST_IDLE;
              end else begin
                state  <= ST_RDATA;
                txb    <= ld_byte;
                rword  <= ld_word << BYTE_W;
                sda_oe <= ~ld_byte[7];
              end
            end
          end

          default: ;
        endcase
      end
    end
  end

  assign rf_raddr = ptr;

endmodule

// File: rtl/twi_reg_slave.sv
module twi_reg_slave #(
  parameter logic [6:0] DEV_ADDR    = 7'b1011100,
  parameter int         AW          = 8,
  parameter int         DW          = 16,
  parameter int         SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  output logic          rf_we,
  output logic [AW-1:0] rf_waddr,
  output logic [DW-1:0] rf_wdata,
  output logic [AW-1:0] rf_raddr,
  input  logic [DW-1:0] rf_rdata
);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  twi_bus_events #(.SYNC_STAGES(SYNC_STAGES)) u_events (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  twi_ctrl #(.DEV_ADDR(DEV_ADDR), .AW(AW), .DW(DW)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .sda_s     (sda_s),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_oe    (sda_oe),
    .rf_we     (rf_we),
    .rf_waddr  (rf_waddr),
    .rf_wdata  (rf_wdata),
    .rf_raddr  (rf_raddr),
    .rf_rdata  (rf_rdata)
  );

endmodule

// File: rtl/twi_reg_slave_chk.sv
module twi_reg_slave_chk (
  input logic clk,
  input logic rst,
  input logic scl_s,
  input logic start_det,
  input logic stop_det,
  input logic sda_oe,
  input logic rf_we
);

  // R10: drive changes only while the synchronized clock is low
  p_oe_scl_low_r10: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> !scl_s);

  // R5: write strobe lasts a single cycle
  p_we_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    rf_we |=> !rf_we);

  // R5: a word completes on the falling clock, never while it is high
  p_we_scl_low_r5: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> !scl_s);

  // R2: stop releases the data line
  p_stop_release_r2: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !sda_oe);

  // R7: neither a start nor a stop produces a write of a partial word
  p_start_nowrite_r7: assert property (@(posedge clk) disable iff (rst)
    start_det |=> !rf_we);

  p_stop_nowrite_r7: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !rf_we);

endmodule

bind twi_reg_slave twi_reg_slave_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .scl_s     (scl_s),
  .start_det (start_det),
  .stop_det  (stop_det),
  .sda_oe    (sda_oe),
  .rf_we     (rf_we)
);

// File: tb/tb_twi_reg_slave.sv
`timescale 1ns/1ps
module tb_twi_reg_slave;

  localparam int Q = 8;  // system clocks per quarter bus period

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        scl_m = 1'b1;
  logic        sda_m = 1'b1;
  logic        sda_oe, rf_we;
  logic [7:0]  rf_waddr, rf_raddr;
  logic [15:0] rf_wdata, rf_rdata;
  wire         line = sda_m & ~sda_oe;

  always #2.5 clk = ~clk;

  twi_reg_slave dut (
    .clk      (clk),
    .rst      (rst),
    .scl_i    (scl_m),
    .sda_i    (line),
    .sda_oe   (sda_oe),
    .rf_we    (rf_we),
    .rf_waddr (rf_waddr),
    .rf_wdata (rf_wdata),
    .rf_raddr (rf_raddr),
    .rf_rdata (rf_rdata)
  );

  // Register file model
  logic [15:0] regs [256];
  int          wr_count = 0;
  logic [7:0]  last_waddr;
  logic [15:0] last_wdata;
  assign rf_rdata = regs[rf_raddr];
  always @(posedge clk) begin
    if (rf_we) begin
      regs[rf_waddr] <= rf_wdata;
      wr_count       <= wr_count + 1;
      last_waddr     <= rf_waddr;
      last_wdata     <= rf_wdata;
    end
  end

  // Watch for the data line moving while the clock is high and the master holds still
  int   viol = 0;
  logic scl_p = 1'b1, sda_p = 1'b1, line_p = 1'b1;
  always @(negedge clk) begin
    if (!rst && scl_m && scl_p && sda_m == sda_p && line != line_p) viol++;
    scl_p  <= scl_m;
    sda_p  <= sda_m;
    line_p <= line;
  end

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic qw();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; qw(); scl_m = 1'b1; qw(); sda_m = 1'b0; qw(); scl_m = 1'b0; qw();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; qw(); scl_m = 1'b1; qw(); sda_m = 1'b1; qw(); qw();
  endtask

  task automatic wr_bit(input logic b);
    sda_m = b; qw(); scl_m = 1'b1; qw(); qw(); scl_m = 1'b0; qw();
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) wr_bit(b[i]);
    sda_m = 1'b1; qw(); scl_m = 1'b1; qw(); ack = (line == 1'b0); qw(); scl_m = 1'b0; qw();
  endtask

  task automatic rd_byte(input logic mack, output logic [7:0] d);
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      qw(); scl_m = 1'b1; qw(); d = {d[6:0], line}; qw(); scl_m = 1'b0;
    end
    qw();
    wr_bit(~mack);
  endtask

  // Read n words from addr into the returned packed vector (word 0 in the low bits)
  task automatic rd_words(input logic [7:0] addr, input int n, output logic [63:0] words,
                          output logic acks);
    logic a;
    logic [7:0] hi, lo;
    acks = 1'b1;
    words = '0;
    bus_start();
    wr_byte(8'hB8, a); acks &= a;
    wr_byte(addr, a);  acks &= a;
    bus_start();
    wr_byte(8'hB9, a); acks &= a;
    for (int k = 0; k < n; k++) begin
      rd_byte(1'b1, hi);
      rd_byte(k != n - 1, lo);
      words[k*16 +: 16] = {hi, lo};
    end
    bus_stop();
  endtask

  localparam int NV = 5;
  // {register address, word}
  localparam logic [23:0] VEC [NV] = '{
    24'h01_1234, 24'h7E_A5C3, 24'h80_00FF, 24'hC4_8001, 24'h22_5A5A
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic a, acks;
    logic [7:0] b;
    logic [63:0] w;
    int wc0;

    repeat (5) @(negedge clk);
    check("R1 reset sda_oe", sda_oe, 0);
    check("R1 reset rf_we", rf_we, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 post-reset sda_oe", sda_oe, 0);
    check("R1 post-reset rf_we", rf_we, 0);
    qw();

    // Table of single-word writes, each read back
    for (int v = 0; v < NV; v++) begin
      wc0 = wr_count;
      acks = 1'b1;
      bus_start();
      wr_byte(8'hB8, a);          acks &= a;
      wr_byte(VEC[v][23:16], a);  acks &= a;
      wr_byte(VEC[v][15:8], a);   acks &= a;
      wr_byte(VEC[v][7:0], a);    acks &= a;
      bus_stop();
      check("R3/R4/R5 write acks", acks, 1);
      check("R5 one strobe per word", wr_count - wc0, 1);
      check("R4 write address", last_waddr, VEC[v][23:16]);
      check("R5 write data", last_wdata, VEC[v][15:0]);
      rd_words(VEC[v][23:16], 1, w, acks);
      check("R8 read acks", acks, 1);
      check("R8 readback", w[15:0], VEC[v][15:0]);
    end

    // R3: wrong device address is not acknowledged, later bytes neither
    wc0 = wr_count;
    bus_start();
    wr_byte(8'hA0, a);
    check("R3 foreign address nack", a, 0);
    wr_byte(8'h05, a);
    check("R3 stays released", a, 0);
    wr_byte(8'h99, a);
    wr_byte(8'h77, a);
    bus_stop();
    check("R3 no write when not addressed", wr_count - wc0, 0);

    // R6: three-word burst write, per-word increment
    wc0 = wr_count;
    bus_start();
    wr_byte(8'hB8, a); wr_byte(8'h40, a);
    wr_byte(8'h11, a); wr_byte(8'h22, a);
    wr_byte(8'h33, a); wr_byte(8'h44, a);
    wr_byte(8'h55, a); wr_byte(8'h66, a);
    bus_stop();
    check("R6 burst strobe count", wr_count - wc0, 3);
    check("R6 burst word 0", regs[8'h40], 16'h1122);
    check("R6 burst word 1", regs[8'h41], 16'h3344);
    check("R6 burst word 2", regs[8'h42], 16'h5566);

    // R8: burst read continues on master acknowledge
    rd_words(8'h40, 3, w, acks);
    check("R8 burst read words", w[47:0], 48'h5566_3344_1122);

    // R9: after the master's nack the slave drives nothing
    bus_start();
    wr_byte(8'hB8, a); wr_byte(8'h41, a);
    bus_start();
    wr_byte(8'hB9, a);
    rd_byte(1'b1, b); rd_byte(1'b0, b);
    check("R9 last byte before nack", b, 8'h44);
    rd_byte(1'b0, b);
    check("R9 line released after nack", b, 8'hFF);
    check("R9 no drive after nack", sda_oe, 0);
    bus_stop();
    check("R2 released after stop", sda_oe, 0);

    // R6: pointer wraps from 0xFF to 0x00
    bus_start();
    wr_byte(8'hB8, a); wr_byte(8'hFF, a);
    wr_byte(8'hBE, a); wr_byte(8'hEF, a);
    wr_byte(8'hCA, a); wr_byte(8'hFE, a);
    bus_stop();
    check("R6 wrap last address", last_waddr, 8'h00);
    check("R6 wrap word at 0xFF", regs[8'hFF], 16'hBEEF);
    check("R6 wrap word at 0x00", regs[8'h00], 16'hCAFE);

    // R7: odd byte before a stop is dropped
    wc0 = wr_count;
    bus_start();
    wr_byte(8'hB8, a); wr_byte(8'h30, a);
    wr_byte(8'hAB, a); wr_byte(8'hCD, a); wr_byte(8'hEF, a);
    bus_stop();
    check("R7 stop drops partial word", wr_count - wc0, 1);
    check("R7 full word kept", last_waddr, 8'h30);

    // R7: odd byte before a repeated start is dropped
    wc0 = wr_count;
    bus_start();
    wr_byte(8'hB8, a); wr_byte(8'h50, a); wr_byte(8'h12, a);
    bus_start();
    wr_byte(8'hB8, a); wr_byte(8'h51, a);
    wr_byte(8'h9A, a); wr_byte(8'hBC, a);
    bus_stop();
    check("R7 restart drops partial word", wr_count - wc0, 1);
    check("R7 restart next word address", last_waddr, 8'h51);
    check("R7 restart next word data", last_wdata, 16'h9ABC);

    // R10: line never moved by the slave while the clock was high
    check("R10 drive only while clock low", viol, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule